// File: doc/BRIEF.md
# Signed Bit-Serial Distributed-Arithmetic FIR Filter

This block is a three-tap FIR filter that needs no multiplier. It takes three 4-bit two's-complement samples and works through them one bit position per clock, starting at the least significant bit. At each position, the three current sample bits together form an index into a small table. The table holds every sum that can be made from a subset of the coefficients -2, 3 and 1. A shift-accumulate register gathers the table values into the full sum of products.

The accumulator halves its value on every step, and each table value is scaled by eight before it is added. Because the samples are two's complement, the last step, which handles the sign bit, subtracts the scaled table value instead of adding it. A two-state controller runs the sequence. The first state latches the samples and clears the accumulator. The second state runs four shift steps and then a publish step. This gives one result every six clocks. A new sum of products starts as soon as each result has been published.

Top module: `serial_da_fir`

## Requirements
- R1: While reset (`rstN` low) is applied, `yOut` is 0 and `outValid` is 0.
- R2: Samples are packed with tap 0 in `samples[3:0]`, tap 1 in `samples[7:4]` and tap 2 in `samples[11:8]`, each in 4-bit two's complement. Each published `yOut` equals -2*tap0 + 3*tap1 + 1*tap2 as a 7-bit two's-complement value, for all 4096 sample combinations.
- R3: The first rising edge with reset released latches the samples. A result then comes every 6 clocks: `outValid` is high for exactly one clock, after the 6th rising edge counted from the latching edge. The next latching edge is the one right after that pulse.
- R4: `samples` is sampled only at the latching edge. Changing it during the following five clocks has no effect on the result.
- R5: `yOut` holds its value in every clock in which `outValid` is low.
- R6: The extreme results -46 (tap0=7, tap1=-8, tap2=-8) and 44 (tap0=-8, tap1=7, tap2=7) appear without wrap-around.
- R7: The sign-bit step subtracts. A single negative sample on one tap gives its coefficient times a negative value; for example, tap1=-1 with the other taps at 0 gives -3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| samples | input | 12 | Three packed signed 4-bit samples, tap 0 in the lowest bits |
| yOut | output | 7 | Signed sum of products, held between results |
| outValid | output | 1 | One-clock pulse when `yOut` takes a new result |

## Verification
A result is due after the 6th rising edge counted from the edge that latches the samples. The bench sets new samples on the falling edge where it observes `outValid`, and so on the falling edge right after reset is released. It then counts six falling edges and checks the result only at the last one. At each of the five falling edges in between, it checks that `outValid` is low and that `yOut` still holds the previous result. In the scrambled-input scenario, the samples are changed one clock after the latching edge, and the bench expects the result of the originally latched values.

// File: rtl/serial_da_fir_pkg.sv
package serial_da_fir_pkg;

  // Strobes from the controller to the datapath; at most one is high per clock.
  typedef struct packed {
    logic load;     // latch samples, clear the accumulator
    logic stepAdd;  // shift-accumulate, adding the scaled table value
    logic stepSub;  // sign-bit step, subtracting the scaled table value
    logic publish;  // copy the accumulator to the output
  } daCtl_t;

endpackage

// File: rtl/serial_da_fir_ctrl.sv
module serial_da_fir_ctrl
  import serial_da_fir_pkg::*;
#(
  parameter int DataWidth = 4
) (
  input  logic   clk,
  input  logic   rstN,
  output daCtl_t ctl
);

  localparam int CntWidth = $clog2(DataWidth + 1);
  localparam logic [CntWidth-1:0] LastStep = CntWidth'(DataWidth - 1);
  localparam logic [CntWidth-1:0] DoneCnt  = CntWidth'(DataWidth);

  typedef enum logic {ST_LOAD, ST_SHIFT} ctlState_t;

  ctlState_t         state;
  logic [CntWidth-1:0] stepCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_LOAD;
      stepCnt <= '0;
    end else begin
      case (state)
        ST_LOAD: begin
          stepCnt <= '0;
          state   <= ST_SHIFT;
        end
        default: begin
          if (stepCnt == DoneCnt) begin
            state <= ST_LOAD;
          end else begin
            stepCnt <= stepCnt + 1'b1;
          end
        end
      endcase
    end
  end

  always_comb begin
    ctl = '0;
    if (state == ST_LOAD) begin
      ctl.load = 1'b1;
    end else if (stepCnt == DoneCnt) begin
      ctl.publish = 1'b1;
    end else if (stepCnt == LastStep) begin
      ctl.stepSub = 1'b1;
    end else begin
      ctl.stepAdd = 1'b1;
    end
  end

endmodule

// File: rtl/serial_da_fir_dp.sv
module serial_da_fir_dp
  import serial_da_fir_pkg::*;
#(
  parameter int DataWidth = 4,
  parameter int Taps      = 3,
  parameter int CoefWidth = 3,
  parameter int AccWidth  = 7,
  parameter logic signed [CoefWidth-1:0] Coef [Taps] = '{-3'sd2, 3'sd3, 3'sd1}
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  daCtl_t                     ctl,
  input  logic [Taps*DataWidth-1:0]  samples,
  output logic signed [AccWidth-1:0] yOut,
  output logic                       outValid
);

  localparam int TabWidth = CoefWidth + $clog2(Taps);

  // Partial-sum table: entry = sum of coefficients whose address bit is set.
  function automatic logic signed [TabWidth-1:0] tableLookup(input logic [Taps-1:0] addr);
    logic signed [TabWidth-1:0] sum;
    sum = '0;
    for (int k = 0; k < Taps; k++) begin
      if (addr[k]) sum = sum + TabWidth'(Coef[k]);
    end
    return sum;
  endfunction

  logic [DataWidth-1:0]       sampleReg [Taps];
  logic [Taps-1:0]            tabAddr;
  logic signed [TabWidth-1:0] tabVal;
  logic signed [AccWidth-1:0] acc;
  logic signed [AccWidth-1:0] tabScaled;
  logic signed [AccWidth-1:0] accHalf;

  for (genvar g = 0; g < Taps; g++) begin : g_addr
    assign tabAddr[g] = sampleReg[g][0];
  end

  assign tabVal    = tableLookup(tabAddr);
  assign tabScaled = AccWidth'(tabVal) <<< (DataWidth - 1);
  assign accHalf   = acc >>> 1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc      <= '0;
      yOut     <= '0;
      outValid <= 1'b0;
      for (int k = 0; k < Taps; k++) sampleReg[k] <= '0;
    end else begin
      outValid <= ctl.publish;
      if (ctl.load) begin
        acc <= '0;
        for (int k = 0; k < Taps; k++) sampleReg[k] <= samples[k*DataWidth +: DataWidth];
      end else if (ctl.stepAdd || ctl.stepSub) begin
        acc <= ctl.stepSub ? (accHalf - tabScaled) : (accHalf + tabScaled);
        for (int k = 0; k < Taps; k++) sampleReg[k] <= sampleReg[k] >> 1;
      end
      if (ctl.publish) yOut <= acc;
    end
  end

endmodule

// File: rtl/serial_da_fir.sv
module serial_da_fir
  import serial_da_fir_pkg::*;
#(
  parameter int DataWidth = 4,
  parameter int Taps      = 3,
  parameter int CoefWidth = 3,
  parameter int AccWidth  = 7,
  parameter logic signed [CoefWidth-1:0] Coef [Taps] = '{-3'sd2, 3'sd3, 3'sd1}
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [Taps*DataWidth-1:0]  samples,
  output logic signed [AccWidth-1:0] yOut,
  output logic                       outValid
);

  daCtl_t ctlBus;

  serial_da_fir_ctrl #(.DataWidth(DataWidth)) u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .ctl  (ctlBus)
  );

  serial_da_fir_dp #(
    .DataWidth (DataWidth),
    .Taps      (Taps),
    .CoefWidth (CoefWidth),
    .AccWidth  (AccWidth),
    .Coef      (Coef)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctlBus),
    .samples  (samples),
    .yOut     (yOut),
    .outValid (outValid)
  );

endmodule

// File: rtl/serial_da_fir_chk.sv
module serial_da_fir_chk
  import serial_da_fir_pkg::*;
#(
  parameter int AccWidth = 7
) (
  input logic                clk,
  input logic                rstN,
  input daCtl_t              ctl,
  input logic                outValid,
  input logic [AccWidth-1:0] yOut
);

  // R3
  valid_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  // R5
  output_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(yOut));

  // R3
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.load, ctl.stepAdd, ctl.stepSub, ctl.publish}));

  // R3
  restart_after_publish_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.publish |=> ctl.load);

  // R7
  sign_step_then_publish_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.stepSub |=> ctl.publish);

  // R3
  load_then_add_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> ctl.stepAdd);

  // R3
  valid_follows_publish_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.publish |=> outValid);

endmodule

bind serial_da_fir serial_da_fir_chk #(.AccWidth(AccWidth)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .ctl      (ctlBus),
  .outValid (outValid),
  .yOut     (yOut)
);

// File: tb/tb_serial_da_fir.sv
module tb_serial_da_fir;

  localparam int ClkPeriod = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] samples = '0;
  logic signed [6:0] yOut;
  logic        outValid;

  int checks = 0;
  int fails  = 0;
  int lastY  = 0;
  bit finished = 1'b0;

  serial_da_fir dut (
    .clk      (clk),
    .rstN     (rstN),
    .samples  (samples),
    .yOut     (yOut),
    .outValid (outValid)
  );

  always #(ClkPeriod/2) clk = ~clk;

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  function automatic logic [11:0] pack(input int a, input int b, input int c);
    return {4'(c), 4'(b), 4'(a)};
  endfunction

  // Called on a falling edge whose next rising edge latches the samples.
  task automatic runVector(input int a, input int b, input int c, input bit scramble);
    int expected;
    expected = -2 * a + 3 * b + c;
    samples = pack(a, b, c);
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      if (scramble && i == 1) samples = ~samples;
      if (i < 6) begin
        check("R3 valid low between results", int'(outValid), 0);
        check("R5 output hold", int'(yOut), lastY);
      end else begin
        check("R3 valid pulse on 6th clock", int'(outValid), 1);
        check(scramble ? "R4 scrambled inputs ignored" : "R2 sum of products",
              int'(yOut), expected);
      end
    end
    lastY = expected;
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    check("R1 reset yOut", int'(yOut), 0);
    check("R1 reset outValid", int'(outValid), 0);
    rstN = 1'b1;
  endtask

  task automatic testExtremes();
    runVector(7, -8, -8, 1'b0);   // R6 minimum
    check("R6 minimum -46", int'(yOut), -46);
    runVector(-8, 7, 7, 1'b0);    // R6 maximum
    check("R6 maximum 44", int'(yOut), 44);
  endtask

  task automatic testSignStep();
    runVector(0, -1, 0, 1'b0);    // R7
    check("R7 tap1 -1 gives -3", int'(yOut), -3);
    runVector(-1, 0, 0, 1'b0);    // R7
    check("R7 tap0 -1 gives 2", int'(yOut), 2);
    runVector(0, 0, -8, 1'b0);    // R7
    check("R7 tap2 -8 gives -8", int'(yOut), -8);
  endtask

  task automatic testScramble();
    runVector(3, -5, 6, 1'b1);    // R4
    runVector(-7, 2, -3, 1'b1);   // R4
  endtask

  task automatic testExhaustive();
    for (int a = -8; a < 8; a++)
      for (int b = -8; b < 8; b++)
        for (int c = -8; c < 8; c++)
          runVector(a, b, c, 1'b0);  // R2
  endtask

  initial begin
    testReset();
    testExtremes();
    testSignStep();
    testScramble();
    testExhaustive();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #(ClkPeriod * 190000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule